// File: doc/BRIEF.md
# IDE Register Window Decoder

This block sits behind the bus target logic of an IDE host controller. Every cycle that carries a request, it looks at the I/O byte address, the four byte enables, the direction and the two window enables. It then settles on one of four outcomes:

- serve the access locally;
- hand it on to a secondary peripheral bus;
- end it with a target abort;
- leave it unclaimed.

The address is a dword address, so bits [1:0] are ignored and the byte enables pick lanes 0 to 3. The command window covers eight bytes, which is two dwords. The control window covers four bytes, which is one dword. The base addresses of both windows are parameters.

The block also watches writes to the drive/head byte of the command window. It keeps a shadow copy of the drive-select bit, so that later stages know whether drive 0 or drive 1 is being addressed and can apply that drive's settings.

All outcomes are registered. The response appears one clock after the request as a valid strobe together with a one-hot-or-none set of claim, forward and abort flags. No flag asserted means "ignored".

Top module: `ide_win_decode`

## Requirements
- R1: After a synchronous reset, `rsp_valid`, `rsp_claim`, `rsp_fwd`, `rsp_abort` and `drv_sel` are all 0, so drive 0 is selected.
- R2: A request whose address lies in the enabled command window gives `rsp_claim`=1 one cycle later, for any byte-enable value, including 4'b0000.
- R3: A request in the enabled control window with byte enables exactly 4'b1000 (lane 3 only) gives `rsp_fwd`=1 and no other flag.
- R4: A request in the enabled control window with byte enables exactly 4'b1100 (lanes 2 and 3 as one 16-bit access) gives `rsp_abort`=1 and no other flag.
- R5: Any other byte-enable value in the enabled control window, including 4'b0000, gives `rsp_claim`=1.
- R6: When a window's enable input is 0, a request to that window gives `rsp_valid`=1 with claim, forward and abort all 0, and a write there leaves `drv_sel` unchanged.
- R7: A request outside both windows gives `rsp_valid`=1 with no flag set.
- R8: A write in the enabled command window to dword offset 1 (byte offset 6 is lane 2) with `req_be[2]`=1 loads `req_wdata[20]` (bit 4 of byte 6) into `drv_sel`, visible one cycle later.
- R9: Reads, writes without lane 2 enabled, and writes to command dword offset 0 leave `drv_sel` unchanged.
- R10: `rsp_valid` is 1 exactly in the cycle after each cycle with `req_valid`=1. At most one of claim, forward and abort is set, and none is set while `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W (16) | I/O byte address; bits [1:0] ignored |
| req_be | input | 4 | Active-high byte enables, one per lane |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W (32) | Write data, lane n in bits [8n+7:8n] |
| cmd_en | input | 1 | Command window enable |
| ctl_en | input | 1 | Control window enable |
| rsp_valid | output | 1 | Registered outcome valid |
| rsp_claim | output | 1 | Access served locally |
| rsp_fwd | output | 1 | Access forwarded to the peripheral bus |
| rsp_abort | output | 1 | Access ends in target abort |
| drv_sel | output | 1 | Shadowed drive-select bit |

## Verification
The hardest case to reach from the ports is the drive-select shadow. It must follow only one byte lane of one dword of one window, and only while that window is enabled. To exercise it, the stimulus first sets the bit to 1. It then sends a series of near-miss writes with the same data word, each of which must leave the bit alone:

- the right dword with lane 2 off;
- the other dword with lane 2 on;
- a read of the right byte;
- a write with the window disabled.

Finally it clears the bit with a genuine write. The lane rules of the control window are covered by sweeping all sixteen byte-enable values in both directions. A reset issued while the shadow holds 1 shows that it returns to drive 0.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;

  typedef enum logic [1:0] {
    OUT_IGNORE = 2'd0,
    OUT_CLAIM  = 2'd1,
    OUT_FWD    = 2'd2,
    OUT_ABORT  = 2'd3
  } win_outcome_e;

  localparam int LANES = 4;
  localparam logic [LANES-1:0] LANE_MASK_FWD   = 4'b1000;
  localparam logic [LANES-1:0] LANE_MASK_ABORT = 4'b1100;

endpackage

// File: rtl/ide_win_match.sv
module ide_win_match #(
  parameter int          ADDR_W    = 16,
  parameter int unsigned BASE      = 32'h01F0,
  parameter int          SPAN_LOG2 = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              enable,
  output logic              hit,
  output logic              in_range
);
  localparam logic [ADDR_W-1:0] BASE_V = BASE[ADDR_W-1:0];

  always_comb begin
    in_range = (addr[ADDR_W-1:SPAN_LOG2] == BASE_V[ADDR_W-1:SPAN_LOG2]);
    hit      = in_range && enable;
  end
endmodule

// File: rtl/ide_ctl_lane_rule.sv
module ide_ctl_lane_rule
  import ide_win_pkg::*;
(
  input  logic [LANES-1:0] be,
  output win_outcome_e     outcome
);
  always_comb begin
    if (be == LANE_MASK_ABORT)    outcome = OUT_ABORT;
    else if (be == LANE_MASK_FWD) outcome = OUT_FWD;
    else                          outcome = OUT_CLAIM;
  end
endmodule

// File: rtl/ide_drv_shadow.sv
module ide_drv_shadow #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int SPAN_LOG2 = 3,
  parameter int REG_OFS   = 6,
  parameter int DRV_BIT   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  input  logic [DATA_W-1:0] wdata,
  output logic              drv_sel
);
  localparam int REG_DWORD = REG_OFS / 4;
  localparam int REG_LANE  = REG_OFS % 4;
  localparam int DATA_BIT  = REG_LANE * 8 + DRV_BIT;
  localparam int DW_BITS   = SPAN_LOG2 - 2;
  localparam logic [DW_BITS-1:0] DW_IDX = REG_DWORD[DW_BITS-1:0];

  logic capture;

  always_comb begin
    capture = wr_hit && be[REG_LANE] && (addr[SPAN_LOG2-1:2] == DW_IDX);
  end

  always_ff @(posedge clk) begin
    if (rst)          drv_sel <= 1'b0;
    else if (capture) drv_sel <= wdata[DATA_BIT];
  end
endmodule

// File: rtl/ide_win_decode.sv
module ide_win_decode
  import ide_win_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 32,
  parameter int unsigned CMD_BASE = 32'h01F0,
  parameter int unsigned CTL_BASE = 32'h03F4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              cmd_en,
  input  logic              ctl_en,
  output logic              rsp_valid,
  output logic              rsp_claim,
  output logic              rsp_fwd,
  output logic              rsp_abort,
  output logic              drv_sel
);
  localparam int          NWIN          = 2;
  localparam int          W_CMD         = 0;
  localparam int          W_CTL         = 1;
  localparam int          CMD_SPAN_LOG2 = 3;
  localparam int          CTL_SPAN_LOG2 = 2;
  localparam int unsigned WIN_BASE [NWIN] = '{CMD_BASE, CTL_BASE};
  localparam int          WIN_SPAN [NWIN] = '{CMD_SPAN_LOG2, CTL_SPAN_LOG2};

  logic [NWIN-1:0] win_en;
  logic [NWIN-1:0] win_hit;
  logic [NWIN-1:0] win_rng;
  win_outcome_e    ctl_out;
  win_outcome_e    out_d;

  assign win_en = {ctl_en, cmd_en};

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    ide_win_match #(
      .ADDR_W   (ADDR_W),
      .BASE     (WIN_BASE[w]),
      .SPAN_LOG2(WIN_SPAN[w])
    ) u_match (
      .addr    (req_addr),
      .enable  (win_en[w]),
      .hit     (win_hit[w]),
      .in_range(win_rng[w])
    );
  end

  ide_ctl_lane_rule u_lane (
    .be     (req_be),
    .outcome(ctl_out)
  );

  always_comb begin
    if (win_hit[W_CMD])      out_d = OUT_CLAIM;
    else if (win_hit[W_CTL]) out_d = ctl_out;
    else                     out_d = OUT_IGNORE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_claim <= 1'b0;
      rsp_fwd   <= 1'b0;
      rsp_abort <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_claim <= req_valid && (out_d == OUT_CLAIM);
      rsp_fwd   <= req_valid && (out_d == OUT_FWD);
      rsp_abort <= req_valid && (out_d == OUT_ABORT);
    end
  end

  ide_drv_shadow #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .SPAN_LOG2(CMD_SPAN_LOG2),
    .REG_OFS  (6),
    .DRV_BIT  (4)
  ) u_shadow (
    .clk    (clk),
    .rst    (rst),
    .wr_hit (req_valid && req_write && win_hit[W_CMD]),
    .addr   (req_addr),
    .be     (req_be),
    .wdata  (req_wdata),
    .drv_sel(drv_sel)
  );

  logic unused_rng;
  assign unused_rng = ^win_rng;
endmodule

// File: rtl/ide_win_decode_chk.sv
module ide_win_decode_chk #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 32,
  parameter int unsigned CMD_BASE = 32'h01F0,
  parameter int unsigned CTL_BASE = 32'h03F4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        req_be,
  input logic              req_write,
  input logic [DATA_W-1:0] req_wdata,
  input logic              cmd_en,
  input logic              ctl_en,
  input logic              rsp_valid,
  input logic              rsp_claim,
  input logic              rsp_fwd,
  input logic              rsp_abort,
  input logic              drv_sel
);
  localparam logic [ADDR_W-1:0] CB = CMD_BASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] KB = CTL_BASE[ADDR_W-1:0];

  logic in_cmd, in_ctl, cap;
  assign in_cmd = req_addr[ADDR_W-1:3] == CB[ADDR_W-1:3];
  assign in_ctl = req_addr[ADDR_W-1:2] == KB[ADDR_W-1:2];
  assign cap    = req_valid && req_write && cmd_en && in_cmd && req_addr[2] && req_be[2];

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $countones({rsp_claim, rsp_fwd, rsp_abort}) <= 1);  // R10
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);  // R10
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && !rsp_claim && !rsp_fwd && !rsp_abort);  // R10
  AST_CMD_CLAIM: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cmd_en && in_cmd) |=> rsp_claim);  // R2
  AST_LANE3_FWD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ctl_en && in_ctl && req_be == 4'b1000) |=> rsp_fwd);  // R3
  AST_WORD_ABORT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ctl_en && in_ctl && req_be == 4'b1100) |=> rsp_abort);  // R4
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !cmd_en && !ctl_en) |=> !rsp_claim && !rsp_fwd && !rsp_abort);  // R6
  AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (rst)
    cap |=> drv_sel == $past(req_wdata[20]));  // R8
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(drv_sel));  // R9
endmodule

bind ide_win_decode ide_win_decode_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_BASE(CMD_BASE), .CTL_BASE(CTL_BASE)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .req_be(req_be), .req_write(req_write), .req_wdata(req_wdata),
  .cmd_en(cmd_en), .ctl_en(ctl_en), .rsp_valid(rsp_valid),
  .rsp_claim(rsp_claim), .rsp_fwd(rsp_fwd), .rsp_abort(rsp_abort),
  .drv_sel(drv_sel)
);

// File: tb/sim_ide_win_decode.sv
module sim_ide_win_decode;
  logic        clk = 0;
  logic        rst = 1;
  logic        req_valid = 0;
  logic [15:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic        req_write = 0;
  logic [31:0] req_wdata = '0;
  logic        cmd_en = 0;
  logic        ctl_en = 0;
  logic        rsp_valid, rsp_claim, rsp_fwd, rsp_abort, drv_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit m_drv  = 0;

  int    q_out[$];
  bit    q_drv[$];
  string q_tag[$];

  always #2 clk = ~clk;

  ide_win_decode u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_be(req_be), .req_write(req_write), .req_wdata(req_wdata),
    .cmd_en(cmd_en), .ctl_en(ctl_en), .rsp_valid(rsp_valid),
    .rsp_claim(rsp_claim), .rsp_fwd(rsp_fwd), .rsp_abort(rsp_abort),
    .drv_sel(drv_sel)
  );

  // outcome code: 0 none, 1 claim, 2 forward, 3 abort
  task automatic issue(input logic [15:0] a, input logic [3:0] be, input bit wr,
                       input logic [31:0] wd, input bit ce, input bit le);
    bit    hc, hl, rc, rl;
    int    o;
    string t;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_be = be; req_write = wr;
    req_wdata = wd; cmd_en = ce; ctl_en = le;
    rc = (a[15:3] == 13'h003E);
    rl = (a[15:2] == 14'h00FD);
    hc = rc && ce;
    hl = rl && le;
    if (hc) begin
      o = 1; t = "R2";
      if (wr && a[2] && be[2]) begin m_drv = wd[20]; t = "R8"; end
      else if (wr) t = "R9";
    end else if (hl) begin
      if (be == 4'b1100)      begin o = 3; t = "R4"; end
      else if (be == 4'b1000) begin o = 2; t = "R3"; end
      else                    begin o = 1; t = "R5"; end
    end else begin
      o = 0; t = (rc || rl) ? "R6" : "R7";
    end
    q_out.push_back(o); q_drv.push_back(m_drv); q_tag.push_back(t);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rsp_valid) begin
        int    eo, ao;
        bit    ed;
        string et;
        ao = rsp_abort ? 3 : rsp_fwd ? 2 : rsp_claim ? 1 : 0;
        checks++;
        if (q_out.size() == 0) begin
          fails++;
          $display("FAIL R10 response without request: actual valid=1 expected valid=0");
        end else begin
          eo = q_out.pop_front(); ed = q_drv.pop_front(); et = q_tag.pop_front();
          if (ao != eo || ed != drv_sel ||
              $countones({rsp_claim, rsp_fwd, rsp_abort}) > 1) begin
            fails++;
            $display("FAIL %s addr/outcome: actual out=%0d drv=%0b flags=%b expected out=%0d drv=%0b",
                     et, ao, drv_sel, {rsp_claim, rsp_fwd, rsp_abort}, eo, ed);
          end
        end
      end else begin
        checks++;
        if (rsp_claim || rsp_fwd || rsp_abort) begin
          fails++;
          $display("FAIL R10 flags while idle: actual %b expected 000",
                   {rsp_claim, rsp_fwd, rsp_abort});
        end
      end
    end
  end

  task automatic check_reset();
    checks++;
    if ({rsp_valid, rsp_claim, rsp_fwd, rsp_abort, drv_sel} != 5'b0) begin
      fails++;
      $display("FAIL R1 reset state: actual %b expected 00000",
               {rsp_valid, rsp_claim, rsp_fwd, rsp_abort, drv_sel});
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset();  // R1
    rst = 0;
    // R2: every byte enable, both command dwords
    for (int b = 0; b < 16; b++) begin
      issue(16'h01F0, b[3:0], 0, 32'h0, 1, 1);
      issue(16'h01F4, b[3:0], 0, 32'h0, 1, 1);
    end
    idle(1);
    // R3 R4 R5: control lane sweep, read and write
    for (int b = 0; b < 16; b++) begin
      issue(16'h03F4, b[3:0], 0, 32'h0, 1, 1);
      issue(16'h03F4, b[3:0], 1, 32'hFFFF_FFFF, 1, 1);
    end
    idle(2);
    // R8 / R9 shadow sequence
    issue(16'h01F4, 4'b0100, 1, 32'h0010_0000, 1, 1);  // R8 -> 1
    issue(16'h01F4, 4'b0011, 1, 32'h0000_0000, 1, 1);  // R9 no lane 2
    issue(16'h01F0, 4'b0100, 1, 32'h0000_0000, 1, 1);  // R9 wrong dword
    issue(16'h01F4, 4'b0100, 0, 32'h0000_0000, 1, 1);  // R9 read
    issue(16'h01F4, 4'b0100, 1, 32'h0000_0000, 0, 1);  // R6 disabled write
    idle(1);
    issue(16'h01F4, 4'b1111, 1, 32'h0000_0000, 1, 1);  // R8 -> 0
    issue(16'h01F4, 4'b0100, 1, 32'hFFEF_FFFF, 1, 1);  // R8 stays 0
    issue(16'h01F4, 4'b0100, 1, 32'h0010_0000, 1, 1);  // R8 -> 1
    // R6: disabled windows
    issue(16'h03F4, 4'b1100, 0, 32'h0, 1, 0);
    issue(16'h03F4, 4'b1000, 0, 32'h0, 1, 0);
    issue(16'h01F0, 4'b0001, 0, 32'h0, 0, 1);
    // R7: outside the windows
    issue(16'h01F8, 4'b0001, 0, 32'h0, 1, 1);
    issue(16'h03F0, 4'b1100, 0, 32'h0, 1, 1);
    issue(16'h03F8, 4'b1000, 0, 32'h0, 1, 1);
    issue(16'h01E8, 4'b0100, 1, 32'h0, 1, 1);
    idle(3);
    // R1: reset while shadow holds 1
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    check_reset();  // R1
    m_drv = 0;
    rst = 0;
    issue(16'h01F4, 4'b0001, 0, 32'h0, 1, 1);
    idle(3);
    if (q_out.size() != 0) begin
      checks++; fails++;
      $display("FAIL R10 missing responses: actual %0d pending expected 0", q_out.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule